// File: doc/BRIEF.md
# SDRAM Burst Access Scheduler

This block reorders memory requests between an incoming request queue and an SDRAM command issuer. Each request arrives with its bank, row and column already decoded, a write flag and a tag. The scheduler keeps a separate age-ordered buffer per bank. It hands out one request per cycle through a valid/ready output.

It chooses the next request so that requests which hit the currently open row of a bank go out back to back as a burst. Reads overtake writes, and writes to the open row are tacked onto the end of a read burst. Banks take turns through a round-robin pointer, so accesses to different banks interleave.

When too many writes are pending, the preference flips to writes until the backlog has drained to half the threshold. Two requests to the same address are never swapped. This keeps a read behind an older write to the location it reads.

Top module: `burst_sched`

## Requirements
- R1: After reset `outValid` is 0 and `inReady` is 1 for every bank.
- R2: `inReady` is 0 while the bank selected by `inBank` holds DEPTH requests. A request offered then is dropped, and requests to other banks are still accepted.
- R3: Once a request to row X of bank B is issued, row X is open in B. Pending requests of B that target X are issued next, in age order, ahead of other rows and other banks, within the run limit of R7.
- R4: With fewer than WR_THRESH writes pending (read mode), a new burst starts with the oldest eligible read of the chosen bank. Inside a burst, open-row reads go before open-row writes, which are appended at the tail. With no eligible request of the preferred type, the oldest request is taken.
- R5: When pending writes reach WR_THRESH, writes become the preferred type. This holds until pending writes fall below WR_THRESH/2.
- R6: A request is never issued while an older request to the same row and column of the same bank is pending.
- R7: Without a live burst, the first bank at or after the round-robin pointer that holds a request is granted. The pointer moves to one past each granted bank. A burst holds its bank for at most MAX_RUN consecutive grants.
- R8: A request leaves the buffer only when `outValid` and `outReady` are both 1, at most one per cycle. While `outReady` is 0 nothing is removed.
- R9: Every accepted request is issued exactly once. `outValid` is 1 exactly when some request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming request present |
| inReady | output | 1 | Buffer of bank `inBank` has room |
| inBank | input | BANK_W | Target bank |
| inRow | input | ROW_W | Target row |
| inCol | input | COL_W | Target column |
| inWrite | input | 1 | 1 = write, 0 = read |
| inTag | input | TAG_W | Request tag |
| outValid | output | 1 | A selected request is offered |
| outReady | input | 1 | Issuer accepts the offered request |
| outBank | output | BANK_W | Bank of the offered request |
| outRow | output | ROW_W | Row of the offered request |
| outCol | output | COL_W | Column of the offered request |
| outWrite | output | 1 | Write flag of the offered request |
| outTag | output | TAG_W | Tag of the offered request |

## Verification
The bench builds the block with its defaults: four banks, eight entries per bank, a write threshold of six and a run limit of four. With these values, six writes in one bank are enough to enter write mode. Six reads to one row are enough to hit the run limit and force a hand-over to another bank. Eight requests to a single bank fill it, which exercises backpressure. The bench loads each scenario with `outReady` held low and then drains it, so the whole issue order, including same-address blocking and write piggybacking, is fixed and checked.

// File: rtl/sched_pkg.sv
package sched_pkg;
  parameter int BANK_W = 2;
  parameter int ROW_W  = 12;
  parameter int COL_W  = 8;
  parameter int TAG_W  = 8;

  typedef struct packed {
    logic             write;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [TAG_W-1:0] tag;
  } req_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              pop;
    logic [BANK_W-1:0] bank;
    logic              wrMode;
  } strb_t;
endpackage

// File: rtl/sched_datapath.sv
module sched_datapath
  import sched_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [BANK_W-1:0]         inBank,
  input  req_t                      inReq,
  output logic                      inReady,
  input  strb_t                     strb,
  output logic [(1<<BANK_W)-1:0]    hasReq,
  output logic [(1<<BANK_W)-1:0]    hasHit,
  output logic [$clog2((1<<BANK_W)*DEPTH+1)-1:0] wrCnt,
  output req_t                      selReq
);
  localparam int NB    = 1 << BANK_W;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int WC_W  = $clog2(NB * DEPTH + 1);

  logic [CNT_W-1:0] cntArr  [NB];
  req_t             candArr [NB];
  logic             accept;

  assign inReady = (cntArr[inBank] != CNT_W'(DEPTH));
  assign accept  = inValid & inReady;
  assign selReq  = candArr[strb.bank];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    req_t             memL [DEPTH];
    logic [CNT_W-1:0] cntL;
    logic [ROW_W-1:0] openRowL;
    logic             rowOpenL;
    logic [IDX_W-1:0] idxL;
    logic             hitAnyL;
    logic             pushB, popB;

    assign pushB      = accept && (inBank == BANK_W'(b));
    assign popB       = strb.pop && (strb.bank == BANK_W'(b));
    assign cntArr[b]  = cntL;
    assign candArr[b] = memL[idxL];
    assign hasReq[b]  = (cntL != '0);
    assign hasHit[b]  = hitAnyL;

    // candidate pick: tier1 open-row + preferred type, tier2 open-row,
    // tier3 preferred type, else the oldest entry
    always_comb begin
      logic f1, f2, f3, blk, hit;
      logic [IDX_W-1:0] i1, i2, i3;
      f1 = 1'b0; f2 = 1'b0; f3 = 1'b0;
      i1 = '0;   i2 = '0;   i3 = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
        blk = 1'b0;
        for (int j = 0; j < i; j++)
          if (memL[j].row == memL[i].row && memL[j].col == memL[i].col) blk = 1'b1;
        hit = rowOpenL && (memL[i].row == openRowL);
        if ((i < int'(cntL)) && !blk) begin
          if (hit && (memL[i].write == strb.wrMode)) begin f1 = 1'b1; i1 = IDX_W'(i); end
          if (hit) begin f2 = 1'b1; i2 = IDX_W'(i); end
          if (memL[i].write == strb.wrMode) begin f3 = 1'b1; i3 = IDX_W'(i); end
        end
      end
      hitAnyL = f2;
      idxL    = f1 ? i1 : (f2 ? i2 : (f3 ? i3 : '0));
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntL     <= '0;
        rowOpenL <= 1'b0;
        openRowL <= '0;
      end else begin
        if (popB) begin
          for (int i = 0; i < DEPTH - 1; i++)
            if (IDX_W'(i) >= idxL) memL[i] <= memL[i+1];
          openRowL <= memL[idxL].row;
          rowOpenL <= 1'b1;
        end
        if (pushB) memL[IDX_W'(popB ? cntL - 1'b1 : cntL)] <= inReq;
        cntL <= cntL + CNT_W'(pushB) - CNT_W'(popB);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrCnt <= '0;
    else wrCnt <= wrCnt + WC_W'(accept && inReq.write) - WC_W'(strb.pop && selReq.write);
  end
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WR_THRESH = 6,
  parameter int MAX_RUN   = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [(1<<BANK_W)-1:0]    hasReq,
  input  logic [(1<<BANK_W)-1:0]    hasHit,
  input  logic [$clog2((1<<BANK_W)*DEPTH+1)-1:0] wrCnt,
  input  logic                      outReady,
  output logic                      outValid,
  output strb_t                     strb,
  output logic [$clog2(MAX_RUN+1)-1:0] runCnt
);
  localparam int NB    = 1 << BANK_W;
  localparam int RUN_W = $clog2(MAX_RUN + 1);

  logic [BANK_W-1:0] ptr, lastBank, rrBank;
  logic              wrModeQ, wrModeEff, contOk;

  always_comb begin
    logic [BANK_W-1:0] idx;
    rrBank = ptr;
    for (int k = NB - 1; k >= 0; k--) begin
      idx = ptr + BANK_W'(k);
      if (hasReq[idx]) rrBank = idx;
    end
  end

  assign wrModeEff = (int'(wrCnt) >= WR_THRESH) ||
                     (wrModeQ && (int'(wrCnt) >= WR_THRESH / 2));
  assign contOk    = (runCnt != '0) && (runCnt < RUN_W'(MAX_RUN)) && hasHit[lastBank];
  assign outValid  = |hasReq;

  assign strb.pop    = outValid && outReady;
  assign strb.bank   = contOk ? lastBank : rrBank;
  assign strb.wrMode = wrModeEff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      lastBank <= '0;
      runCnt   <= '0;
      wrModeQ  <= 1'b0;
    end else begin
      wrModeQ <= wrModeEff;
      if (strb.pop) begin
        lastBank <= strb.bank;
        ptr      <= strb.bank + 1'b1;
        runCnt   <= contOk ? runCnt + 1'b1 : RUN_W'(1);
      end
    end
  end
endmodule

// File: rtl/burst_sched.sv
module burst_sched
  import sched_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WR_THRESH = 6,
  parameter int MAX_RUN   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BANK_W-1:0] inBank,
  input  logic [ROW_W-1:0]  inRow,
  input  logic [COL_W-1:0]  inCol,
  input  logic              inWrite,
  input  logic [TAG_W-1:0]  inTag,
  output logic              outValid,
  input  logic              outReady,
  output logic [BANK_W-1:0] outBank,
  output logic [ROW_W-1:0]  outRow,
  output logic [COL_W-1:0]  outCol,
  output logic              outWrite,
  output logic [TAG_W-1:0]  outTag
);
  localparam int NB    = 1 << BANK_W;
  localparam int WC_W  = $clog2(NB * DEPTH + 1);
  localparam int RUN_W = $clog2(MAX_RUN + 1);

  strb_t            strb;
  req_t             inReq, selReq;
  logic [NB-1:0]    hasReq, hasHit;
  logic [WC_W-1:0]  wrCnt;
  logic [RUN_W-1:0] runCnt;

  assign inReq = '{write: inWrite, row: inRow, col: inCol, tag: inTag};

  sched_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBank(inBank), .inReq(inReq),
    .inReady(inReady), .strb(strb), .hasReq(hasReq), .hasHit(hasHit),
    .wrCnt(wrCnt), .selReq(selReq)
  );

  sched_ctrl #(.DEPTH(DEPTH), .WR_THRESH(WR_THRESH), .MAX_RUN(MAX_RUN)) u_ctl (
    .clk(clk), .rstN(rstN), .hasReq(hasReq), .hasHit(hasHit), .wrCnt(wrCnt),
    .outReady(outReady), .outValid(outValid), .strb(strb), .runCnt(runCnt)
  );

  assign outBank  = strb.bank;
  assign outRow   = selReq.row;
  assign outCol   = selReq.col;
  assign outWrite = selReq.write;
  assign outTag   = selReq.tag;
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int WR_THRESH = 6,
  parameter int MAX_RUN   = 4,
  parameter int WC_W      = 6,
  parameter int RUN_W     = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic             outReady,
  input logic             wrMode,
  input logic [WC_W-1:0]  wrCnt,
  input logic [RUN_W-1:0] runCnt
);
  // R5: threshold reached forces write preference
  p_wr_enter_r5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(wrCnt) >= WR_THRESH) |-> wrMode);
  // R5: below half the threshold the preference is back on reads
  p_wr_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(wrCnt) < WR_THRESH / 2) |-> !wrMode);
  // R7: a burst never holds its bank beyond the run limit
  p_run_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (int'(runCnt) <= MAX_RUN));
  // R8: an offered request that is not taken stays offered
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
  // R9: with no arrival and no grant, an idle output stays idle
  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && !inValid) |=> !outValid);
endmodule

bind burst_sched sched_checker #(
  .WR_THRESH(WR_THRESH), .MAX_RUN(MAX_RUN), .WC_W(WC_W), .RUN_W(RUN_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outReady(outReady), .wrMode(strb.wrMode), .wrCnt(wrCnt), .runCnt(runCnt)
);

// File: tb/sim_burst_sched.sv
`timescale 1ns/1ps
module sim_burst_sched;
  import sched_pkg::*;

  typedef struct {
    int    tag;
    int    bank;
    string req;
  } exp_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inWrite = 1'b0, outReady = 1'b0;
  logic [BANK_W-1:0] inBank = '0;
  logic [ROW_W-1:0]  inRow = '0;
  logic [COL_W-1:0]  inCol = '0;
  logic [TAG_W-1:0]  inTag = '0;
  logic inReady, outValid, outWrite;
  logic [BANK_W-1:0] outBank;
  logic [ROW_W-1:0]  outRow;
  logic [COL_W-1:0]  outCol;
  logic [TAG_W-1:0]  outTag;

  int nChecks = 0, nFails = 0, cycles = 0;
  exp_t expQ[$];

  always #10 clk = ~clk;

  burst_sched u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inBank(inBank),
    .inRow(inRow), .inCol(inCol), .inWrite(inWrite), .inTag(inTag),
    .outValid(outValid), .outReady(outReady), .outBank(outBank), .outRow(outRow),
    .outCol(outCol), .outWrite(outWrite), .outTag(outTag)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic doReset();
    inValid = 1'b0; outReady = 1'b0; rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic sendReq(input int bank, input int row, input int col, input bit wr, input int tag);
    inValid = 1'b1; inBank = BANK_W'(bank); inRow = ROW_W'(row);
    inCol = COL_W'(col); inWrite = wr; inTag = TAG_W'(tag);
    @(posedge clk); #1 inValid = 1'b0;
  endtask

  task automatic expectItem(input int tag, input int bank, input string req);
    exp_t e;
    e.tag = tag; e.bank = bank; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic drain(input string req);
    repeat (3) @(posedge clk);
    #1 outReady = 1'b1;
    for (int k = 0; k < 200 && expQ.size() != 0; k++) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
    check(expQ.size() == 0, {req, " all expected grants seen"}, expQ.size(), 0);
    check(outValid == 1'b0, "R9 idle after drain", outValid, 0);
    outReady = 1'b0;
    expQ.delete();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected grant", int'(outTag), -1);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(int'(outTag) == e.tag, {e.req, " tag"}, int'(outTag), e.tag);
        check(int'(outBank) == e.bank, {e.req, " bank"}, int'(outBank), e.bank);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    #1;
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    for (int b = 0; b < 4; b++) begin
      inBank = BANK_W'(b); #1;
      check(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    end

    // R3 burst on open row, R7 bank interleave
    sendReq(0, 5, 1, 0, 1);
    sendReq(1, 2, 0, 0, 2);
    sendReq(0, 7, 0, 0, 3);
    sendReq(0, 5, 2, 0, 4);
    @(negedge clk);
    check(outValid == 1'b1, "R9 valid with pending", outValid, 1);
    expectItem(1, 0, "R3"); expectItem(4, 0, "R3");
    expectItem(2, 1, "R7"); expectItem(3, 0, "R7");
    drain("R3");

    // R7 run cap
    doReset();
    for (int c = 0; c < 6; c++) sendReq(0, 3, c, 0, 10 + c);
    sendReq(1, 1, 0, 0, 20);
    for (int t = 10; t < 14; t++) expectItem(t, 0, "R7 run");
    expectItem(20, 1, "R7 cap");
    expectItem(14, 0, "R7 resume"); expectItem(15, 0, "R7 resume");
    drain("R7");

    // R4 reads first, writes piggybacked
    doReset();
    sendReq(2, 4, 0, 1, 30);
    sendReq(2, 4, 1, 1, 31);
    sendReq(2, 4, 2, 0, 32);
    sendReq(2, 9, 0, 0, 33);
    expectItem(32, 2, "R4 read first"); expectItem(30, 2, "R4 piggyback");
    expectItem(31, 2, "R4 piggyback");  expectItem(33, 2, "R4 next row");
    drain("R4");

    // R5 write mode at threshold
    doReset();
    for (int c = 0; c < 6; c++) sendReq(3, 1, c, 1, 40 + c);
    sendReq(3, 2, 0, 0, 46);
    for (int t = 40; t < 46; t++) expectItem(t, 3, "R5 writes first");
    expectItem(46, 3, "R5 read last");
    drain("R5");

    // R6 same-address order
    doReset();
    sendReq(1, 6, 3, 1, 60);
    sendReq(1, 6, 3, 0, 61);
    sendReq(1, 8, 0, 0, 62);
    expectItem(62, 1, "R6 free read"); expectItem(60, 1, "R6 older write");
    expectItem(61, 1, "R6 blocked read");
    drain("R6");

    // R2 backpressure and R8 no removal while not ready
    doReset();
    for (int c = 0; c < 8; c++) sendReq(0, 0, c, 0, 70 + c);
    inBank = BANK_W'(0); #1;
    check(inReady == 1'b0, "R2 full bank not ready", inReady, 0);
    inBank = BANK_W'(1); #1;
    check(inReady == 1'b1, "R2 other bank ready", inReady, 1);
    sendReq(0, 0, 9, 0, 78);
    repeat (5) @(posedge clk);
    #1 inBank = BANK_W'(0); #1;
    check(inReady == 1'b0, "R8 nothing removed while not ready", inReady, 0);
    for (int t = 70; t < 78; t++) expectItem(t, 0, "R2 stored");
    drain("R2");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule